// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small microcontroller core. It holds six 11-bit program counter values. Software cannot read or write it. A subroutine call or an interrupt acknowledge pushes the program counter presented on `pcIn`. A return, whether from a subroutine or from an interrupt, pops the newest entry. The entry that would be popped is always visible on `popAddr`, so the sequencer can load it into the program counter in the same cycle as the return.

The block also decides when an interrupt may be taken. A pending request is acknowledged only when the stack has a free level and no call or return is using the stack in that cycle. While the stack is full the request stays pending, and it is taken in the cycle after a return frees a level. A call on a full stack does not stall: the oldest address is overwritten, and the six newest addresses remain.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: `empty`=1, `full`=0, `underflow`=0 and `popAddr`=0.
- R2: A cycle with `pushCall`=1 stores `pcIn` as the newest entry, and `popAddr` shows it from the next cycle. `full` rises after the sixth stored entry.
- R3: While the stack is not empty, `popAddr` shows the newest entry. A cycle with `popReq`=1 removes that entry, so that entries come back in last-in, first-out order.
- R4: `irqAck` is 1 exactly when `irqPending`=1, `full`=0, `pushCall`=0 and `popReq`=0. An acknowledge pushes `pcIn` just as a call does.
- R5: While the stack is full, a pending interrupt is not acknowledged. After a return frees a level, the interrupt is acknowledged in the following cycle.
- R6: A call on a full stack keeps `full`=1 and discards the oldest entry. The following six returns give the six newest addresses, newest first, and then the stack is empty.
- R7: A return on an empty stack gives `popAddr`=0 and `underflow`=1, and the stack stays empty. `underflow` is 0 in every other cycle.
- R8: When a call and a pending interrupt arrive in the same cycle, the call is pushed and the interrupt waits. Whether the stack is full is judged on the depth before that push, so a call into the last free level holds back the interrupt in the next cycle too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushCall | input | 1 | Subroutine call: push `pcIn` |
| popReq | input | 1 | Return or return-from-interrupt: pop the newest entry |
| irqPending | input | 1 | An unmasked interrupt request is pending |
| pcIn | input | 11 | Program counter value to push |
| irqAck | output | 1 | Interrupt acknowledged in this cycle (also pushes `pcIn`) |
| popAddr | output | 11 | Newest entry, or 0 when the stack is empty |
| full | output | 1 | Six entries held |
| empty | output | 1 | No entries held |
| underflow | output | 1 | Return requested on an empty stack |

## Verification
The assertions assume that `pushCall` and `popReq` are never high in the same cycle. A core issues at most one flow change per instruction, so the two never coincide. Under that assumption, depth changes by at most one level per cycle and the push-then-pop ordering properties stay well defined. The stimulus table and the directed sequences never raise both strobes together. They do combine `irqPending` with a call, with a return, and with a full stack, because those cases exercise the acknowledge gate.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } stackCmd_t;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushCall,
  input  logic      popReq,
  input  logic      irqPending,
  output logic      irqAck,
  output logic      full,
  output logic      empty,
  output logic      underflow,
  output stackCmd_t cmd
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] depth;

  assign full  = (depth == CW'(DEPTH));
  assign empty = (depth == '0);

  // Gate uses the depth held before this cycle's push or pop.
  assign irqAck    = irqPending & ~full & ~pushCall & ~popReq;
  assign underflow = popReq & empty;

  always_comb begin
    cmd.push = pushCall | irqAck;
    cmd.pop  = popReq & ~empty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (cmd.push && !full) begin
      depth <= depth + 1'b1;
    end else if (cmd.pop) begin
      depth <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/ras_datapath.sv
module ras_datapath
  import ras_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  stackCmd_t     cmd,
  input  logic          hasData,
  input  logic [AW-1:0] pcIn,
  output logic [AW-1:0] popAddr
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [AW-1:0] slots [DEPTH];
  logic [IW-1:0] topIdx;
  logic [IW-1:0] nextIdx;
  logic [IW-1:0] prevIdx;

  assign nextIdx = (topIdx == LAST) ? '0 : topIdx + 1'b1;
  assign prevIdx = (topIdx == '0) ? LAST : topIdx - 1'b1;
  assign popAddr = hasData ? slots[topIdx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topIdx <= LAST;
    end else if (cmd.push) begin
      topIdx <= nextIdx;
    end else if (cmd.pop) begin
      topIdx <= prevIdx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slots[g] <= '0;
      end else if (cmd.push && nextIdx == IW'(g)) begin
        slots[g] <= pcIn;
      end
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushCall,
  input  logic          popReq,
  input  logic          irqPending,
  input  logic [AW-1:0] pcIn,
  output logic          irqAck,
  output logic [AW-1:0] popAddr,
  output logic          full,
  output logic          empty,
  output logic          underflow
);
  stackCmd_t cmd;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushCall(pushCall), .popReq(popReq),
    .irqPending(irqPending), .irqAck(irqAck), .full(full), .empty(empty),
    .underflow(underflow), .cmd(cmd)
  );

  ras_datapath #(.AW(AW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hasData(~empty),
    .pcIn(pcIn), .popAddr(popAddr)
  );
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int AW    = 11,
  parameter int DEPTH = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          pushCall,
  input logic          popReq,
  input logic          irqPending,
  input logic [AW-1:0] pcIn,
  input logic          irqAck,
  input logic [AW-1:0] popAddr,
  input logic          full,
  input logic          empty,
  input logic          underflow
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_push_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pushCall && !popReq) |=> !empty);

  p_lifo_top_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(pushCall) && !$past(popReq)) |-> popAddr == $past(pcIn));

  p_ack_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> (irqPending && !pushCall && !popReq));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !irqAck);

  p_overflow_keeps_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushCall) |=> full);

  p_underflow_stays_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> empty);

  p_underflow_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (popAddr == '0));

  p_call_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    pushCall |-> !irqAck);

  p_status_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
endmodule

bind ret_addr_stack ras_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushCall(pushCall), .popReq(popReq),
  .irqPending(irqPending), .pcIn(pcIn), .irqAck(irqAck), .popAddr(popAddr),
  .full(full), .empty(empty), .underflow(underflow)
);

// File: tb/sim_ret_addr_stack.sv
`timescale 1ns/1ps
module sim_ret_addr_stack;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushCall = 1'b0, popReq = 1'b0, irqPending = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic irqAck, full, empty, underflow;
  logic [AW-1:0] popAddr;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ret_addr_stack #(.AW(AW), .DEPTH(6)) u0 (
    .clk(clk), .rstN(rstN), .pushCall(pushCall), .popReq(popReq),
    .irqPending(irqPending), .pcIn(pcIn), .irqAck(irqAck), .popAddr(popAddr),
    .full(full), .empty(empty), .underflow(underflow)
  );

  // {push, pop, irq, pc[10:0], expAck, expPop[10:0], expFull, expEmpty, expUnder}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,11'h000, 1'b0,11'h000,1'b0,1'b1,1'b0},
    {1'b1,1'b0,1'b0,11'h101, 1'b0,11'h000,1'b0,1'b1,1'b0},
    {1'b1,1'b0,1'b0,11'h102, 1'b0,11'h101,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b1,11'h203, 1'b1,11'h102,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,11'h000, 1'b0,11'h203,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,11'h000, 1'b0,11'h102,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,11'h000, 1'b0,11'h101,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,11'h000, 1'b0,11'h000,1'b0,1'b1,1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later, then let the rising edge commit.
  task automatic step(input logic p, input logic q, input logic i,
                      input logic [AW-1:0] pc);
    @(negedge clk);
    pushCall = p; popReq = q; irqPending = i; pcIn = pc;
    #1;
  endtask

  task automatic idleAll();
    @(negedge clk);
    pushCall = 0; popReq = 0; irqPending = 0; pcIn = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 underflow", int'(underflow), 0);
    check("R1 popAddr", int'(popAddr), 0);

    // Table walk: R2 push, R3 LIFO pop, R4 ack pushes pc, R7 underflow
    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      v = VEC[k];
      step(v[28], v[27], v[26], v[25:15]);
      check("R4 table irqAck", int'(irqAck), int'(v[14]));
      check("R3 table popAddr", int'(popAddr), int'(v[13:3]));
      check("R2 table full", int'(full), int'(v[2]));
      check("R2 table empty", int'(empty), int'(v[1]));
      check("R7 table underflow", int'(underflow), int'(v[0]));
    end

    // R2: fill six levels
    for (int k = 1; k <= 6; k++) begin
      step(1, 0, 0, 11'(16'h300 + k));
      check("R2 not full yet", int'(full), 0);
    end
    // R5: full blocks a pending interrupt
    step(0, 0, 1, 11'h3AA);
    check("R2 full after six", int'(full), 1);
    check("R5 ack withheld", int'(irqAck), 0);
    step(0, 1, 1, 11'h3AA);
    check("R4 no ack with pop", int'(irqAck), 0);
    check("R3 pop newest", int'(popAddr), 'h306);
    step(0, 0, 1, 11'h3AA);
    check("R5 ack after pop", int'(irqAck), 1);
    step(0, 1, 0, 11'h000);
    check("R4 ack pushed pc", int'(popAddr), 'h3AA);
    check("R5 full again", int'(full), 1);

    // R8: call with pending interrupt at depth five
    step(1, 0, 1, 11'h3B0);
    check("R8 call wins", int'(irqAck), 0);
    check("R8 not full before", int'(full), 0);
    step(0, 0, 1, 11'h000);
    check("R8 full from call", int'(full), 1);
    check("R8 ack still withheld", int'(irqAck), 0);

    // R6: two calls on a full stack drop the two oldest
    step(1, 0, 0, 11'h3C1);
    step(1, 0, 0, 11'h3C2);
    step(0, 0, 0, 11'h000);
    check("R6 full kept", int'(full), 1);
    check("R6 newest on top", int'(popAddr), 'h3C2);
    begin
      logic [AW-1:0] expSeq [6];
      expSeq = '{11'h3C2, 11'h3C1, 11'h3B0, 11'h305, 11'h304, 11'h303};
      for (int k = 0; k < 6; k++) begin
        step(0, 1, 0, 11'h000);
        check("R6 pop order", int'(popAddr), int'(expSeq[k]));
        check("R7 no underflow", int'(underflow), 0);
      end
    end
    step(0, 1, 0, 11'h000);
    check("R6 empty after six", int'(empty), 1);
    check("R7 underflow flag", int'(underflow), 1);
    check("R7 zero on empty pop", int'(popAddr), 0);
    step(0, 0, 0, 11'h000);
    check("R7 stays empty", int'(empty), 1);
    check("R7 underflow clears", int'(underflow), 0);

    // R4: interrupt on empty stack acknowledged and pushed
    step(0, 0, 1, 11'h155);
    check("R4 ack when free", int'(irqAck), 1);
    step(0, 0, 0, 11'h000);
    check("R4 pushed by ack", int'(popAddr), 'h155);
    idleAll();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule